// File: doc/BRIEF.md
# Multi-source sample strobe merger and bus demultiplexer

This block is the input stage of a synchronous state-capture instrument. Five external sample-strobe lines are oversampled in a fast system clock domain. Each line can be enabled and given its own active edge. The active edges of the enabled lines are ORed into one master capture event. On every master event the block emits a single-cycle valid pulse that carries one assembled sample word.

Two hold-strobe lines let one probe capture both phases of a multiplexed address/data bus. On a hold edge, each data group in multiplexed mode latches its data. That value stays in the latch until a later hold edge replaces it. At the next master event it is placed next to the live data of the same group.

A run request starts and stops acquisition. The start clears the hold latches and the missed-hold flag. A run/stop line with programmable polarity reports whether acquisition is running.

Top module: `strobe_front`

## Requirements
- R1: After reset, `cap_valid` and `hold_miss` are 0 and `runstop_out` equals `runstop_inv`, which is the idle level.
- R2: A sample line takes part in the master event only when its bit in `smp_en` is 1. Edges on disabled lines produce no capture.
- R3: Bit i of `smp_fall` selects the active edge of sample line i: 0 means rising, 1 means falling. The opposite edge produces no capture.
- R4: A capture pulse rises on `cap_valid` three system clock edges after the active strobe edge appears at the input. It lasts exactly one cycle.
- R5: Active edges on several enabled lines that arrive in the same system cycle produce exactly one capture pulse.
- R6: A hold line latches data only when its `hold_en` bit is 1. Its active edge is set by `hold_fall` (0 means rising, 1 means falling). Group g is latched by the hold line whose index is in `grp_hsel[g*HSEL_W +: HSEL_W]`. Hold edges are ignored while acquisition is stopped.
- R7: Group g occupies `cap_word[g*2*GROUP_W +: 2*GROUP_W]`. The lower half holds the live data at the capture. The upper half holds the hold-latched data when `grp_mux[g]` is 1, and zero when the group is in normal mode.
- R8: A latched hold value is kept across any number of captures until a new hold edge for that group replaces it.
- R9: The cycle in which acquisition starts clears every hold latch to zero. It also clears `hold_miss`.
- R10: `hold_miss` goes to 1 at a capture if some multiplexed group has had no hold edge since the previous capture or since the start. It then stays at 1 until the next start.
- R11: `runstop_out` is the running state XOR `runstop_inv`. The running state follows `run_req` one cycle later. No capture happens while acquisition is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | NUM_SMP | External sample-strobe lines |
| smp_en | input | NUM_SMP | Per-line enable for the master event |
| smp_fall | input | NUM_SMP | Per-line active edge, 1 means falling |
| hold_in | input | NUM_HOLD | External hold-strobe lines |
| hold_en | input | NUM_HOLD | Per-line hold enable |
| hold_fall | input | NUM_HOLD | Per-line hold polarity, 1 means falling edge |
| data_in | input | NUM_GRP*GROUP_W | Probe data, one slice per group |
| grp_mux | input | NUM_GRP | Per-group multiplexed mode |
| grp_hsel | input | NUM_GRP*HSEL_W | Hold line index for each group |
| run_req | input | 1 | Acquisition run request |
| runstop_inv | input | 1 | Run/stop output polarity |
| cap_valid | output | 1 | Single-cycle capture pulse |
| cap_word | output | NUM_GRP*2*GROUP_W | Assembled sample word |
| hold_miss | output | 1 | Sticky missed-hold flag |
| runstop_out | output | 1 | Run/stop level |

## Verification
The bench builds the block with five sample lines, two hold lines and two groups of four bits. With these values every combination of enable mask and edge mask, 1024 in all, can be swept. In each combination every line is toggled in both directions, and the number of capture pulses is counted against the expected value. The small data groups keep the assembled words short, so the expected words can be written directly. This covers latching on both polarities, disabled hold lines, keeping a latched value across captures, clearing at restart and the sticky missed-hold flag. The coincident-edge case and the exact three-cycle latency are checked on their own.

// File: rtl/strobe_front_pkg.sv
package strobe_front_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    localparam int SYNC_STAGES = 2;

    function automatic logic pick_edge(input logic rise, input logic fall, input logic sel);
        return (edge_sel_e'(sel) == EDGE_FALL) ? fall : rise;
    endfunction

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
    parameter int N      = 5,
    parameter int STAGES = strobe_front_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] chain [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s <= STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s <= STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] the previous level
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];

    // R4: an edge on a line lasts only one cycle
    assert_edge_single_R4: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/strobe_data_delay.sv
module strobe_data_delay #(
    parameter int W      = 16,
    parameter int STAGES = strobe_front_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/strobe_hold_bank.sv
module strobe_hold_bank #(
    parameter int GROUP_W  = 8,
    parameter int NUM_GRP  = 2,
    parameter int NUM_HOLD = 2,
    localparam int HSEL_W  = (NUM_HOLD > 1) ? $clog2(NUM_HOLD) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        cap,
    input  logic [NUM_HOLD-1:0]         hold_hit,
    input  logic [NUM_GRP*HSEL_W-1:0]   grp_hsel,
    input  logic [NUM_GRP*GROUP_W-1:0]  din,
    output logic [NUM_GRP*GROUP_W-1:0]  latched,
    output logic [NUM_GRP-1:0]          seen
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [HSEL_W-1:0] sel;
        logic              load;
        assign sel  = grp_hsel[g*HSEL_W +: HSEL_W];
        assign load = (int'(sel) < NUM_HOLD) ? hold_hit[sel] : 1'b0;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                latched[g*GROUP_W +: GROUP_W] <= '0;
                seen[g]                       <= 1'b0;
            end else begin
                if (load) latched[g*GROUP_W +: GROUP_W] <= din[g*GROUP_W +: GROUP_W];
                if (load)     seen[g] <= 1'b1;
                else if (cap) seen[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/strobe_front.sv
module strobe_front #(
    parameter int NUM_SMP  = 5,
    parameter int NUM_HOLD = 2,
    parameter int GROUP_W  = 8,
    parameter int NUM_GRP  = 2,
    localparam int HSEL_W  = (NUM_HOLD > 1) ? $clog2(NUM_HOLD) : 1,
    localparam int DATA_W  = NUM_GRP * GROUP_W,
    localparam int WORD_W  = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SMP-1:0]         smp_in,
    input  logic [NUM_SMP-1:0]         smp_en,
    input  logic [NUM_SMP-1:0]         smp_fall,
    input  logic [NUM_HOLD-1:0]        hold_in,
    input  logic [NUM_HOLD-1:0]        hold_en,
    input  logic [NUM_HOLD-1:0]        hold_fall,
    input  logic [DATA_W-1:0]          data_in,
    input  logic [NUM_GRP-1:0]         grp_mux,
    input  logic [NUM_GRP*HSEL_W-1:0]  grp_hsel,
    input  logic                       run_req,
    input  logic                       runstop_inv,
    output logic                       cap_valid,
    output logic [WORD_W-1:0]          cap_word,
    output logic                       hold_miss,
    output logic                       runstop_out
);
    import strobe_front_pkg::*;

    logic [NUM_SMP-1:0]  s_rise, s_fall, s_hit;
    logic [NUM_HOLD-1:0] h_rise, h_fall, h_hit;
    logic [DATA_W-1:0]   d_al, latch_bus;
    logic [NUM_GRP-1:0]  seen;
    logic [WORD_W-1:0]   word_next;
    logic                running, start, master, capture;

    strobe_edge_sync #(.N(NUM_SMP)) u_smp_sync (
        .clk(clk), .rst(rst), .din(smp_in), .rise(s_rise), .fall(s_fall));

    strobe_edge_sync #(.N(NUM_HOLD)) u_hold_sync (
        .clk(clk), .rst(rst), .din(hold_in), .rise(h_rise), .fall(h_fall));

    strobe_data_delay #(.W(DATA_W)) u_data_dly (
        .clk(clk), .rst(rst), .din(data_in), .dout(d_al));

    for (genvar i = 0; i < NUM_SMP; i++) begin : g_smp
        assign s_hit[i] = smp_en[i] & pick_edge(s_rise[i], s_fall[i], smp_fall[i]);
    end

    for (genvar h = 0; h < NUM_HOLD; h++) begin : g_hold
        assign h_hit[h] = running & hold_en[h] & pick_edge(h_rise[h], h_fall[h], hold_fall[h]);
    end

    assign master  = |s_hit;
    assign start   = run_req & ~running;
    assign capture = running & master;

    strobe_hold_bank #(.GROUP_W(GROUP_W), .NUM_GRP(NUM_GRP), .NUM_HOLD(NUM_HOLD)) u_bank (
        .clk(clk), .rst(rst), .clr(start), .cap(capture), .hold_hit(h_hit),
        .grp_hsel(grp_hsel), .din(d_al), .latched(latch_bus), .seen(seen));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_word
        assign word_next[g*2*GROUP_W +: 2*GROUP_W] =
            {grp_mux[g] ? latch_bus[g*GROUP_W +: GROUP_W] : {GROUP_W{1'b0}},
             d_al[g*GROUP_W +: GROUP_W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            cap_valid <= 1'b0;
            cap_word  <= '0;
            hold_miss <= 1'b0;
        end else begin
            running   <= run_req;
            cap_valid <= capture;
            if (capture) cap_word <= word_next;
            if (start)
                hold_miss <= 1'b0;
            else if (capture && ((grp_mux & ~seen) != '0))
                hold_miss <= 1'b1;
        end
    end

    assign runstop_out = running ^ runstop_inv;

    // R11: a capture needs acquisition running in the cycle before
    assert_pulse_needs_run_R11: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> $past(running));

    // R9: start leaves latches and flag cleared
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (latch_bus == '0 && !hold_miss));

    // R10: the missed-hold flag holds until a start
    assert_miss_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (hold_miss && !start) |=> hold_miss);
endmodule

// File: tb/strobe_front_tb.sv
module strobe_front_tb_top;
    localparam int NS = 5, NH = 2, GW = 4, NG = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] smp_in = '0, smp_en = '0, smp_fall = '0;
    logic [NH-1:0] hold_in = '0, hold_en = '0, hold_fall = '0;
    logic [7:0]    data_in = '0;
    logic [1:0]    grp_mux = '0, grp_hsel = '0;
    logic          run_req = 1'b0, runstop_inv = 1'b0;
    logic          cap_valid, hold_miss, runstop_out;
    logic [15:0]   cap_word;

    int checks = 0, fails = 0, pulses = 0;
    logic [15:0] last_word = '0;

    always #10 clk = ~clk;

    strobe_front #(.NUM_SMP(NS), .NUM_HOLD(NH), .GROUP_W(GW), .NUM_GRP(NG)) dut_i (
        .clk(clk), .rst(rst), .smp_in(smp_in), .smp_en(smp_en), .smp_fall(smp_fall),
        .hold_in(hold_in), .hold_en(hold_en), .hold_fall(hold_fall), .data_in(data_in),
        .grp_mux(grp_mux), .grp_hsel(grp_hsel), .run_req(run_req),
        .runstop_inv(runstop_inv), .cap_valid(cap_valid), .cap_word(cap_word),
        .hold_miss(hold_miss), .runstop_out(runstop_out));

    always @(negedge clk) if (cap_valid) begin
        pulses    <= pulses + 1;
        last_word <= cap_word;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 cap_valid", cap_valid, 0);
        chk("R1 hold_miss", hold_miss, 0);
        chk("R1 runstop", runstop_out, 0);

        // R2 R3: every enable and edge combination
        for (int cfg = 0; cfg < 1024; cfg++) begin
            run_req = 1'b0; smp_in = '0;
            smp_en = cfg[4:0]; smp_fall = cfg[9:5];
            step(5);
            run_req = 1'b1;
            step(2);
            for (int i = 0; i < NS; i++) begin
                for (int lvl = 1; lvl >= 0; lvl--) begin
                    pulses = 0;
                    smp_in[i] = lvl[0];
                    step(5);
                    chk(lvl == 1 ? "R2/R3 rise" : "R2/R3 fall", pulses,
                        (smp_en[i] && (smp_fall[i] == (lvl == 0))) ? 1 : 0);
                end
            end
        end

        // R4: latency and width
        run_req = 1'b0; smp_in = '0; smp_en = 5'b00100; smp_fall = '0;
        step(5); run_req = 1'b1; step(2);
        smp_in[2] = 1'b1;
        step(2); chk("R4 early", cap_valid, 0);
        step(1); chk("R4 pulse", cap_valid, 1);
        step(1); chk("R4 width", cap_valid, 0);

        // R5: coincident edges
        smp_in = '0; smp_en = '1; step(5); pulses = 0;
        smp_in = '1; step(6);
        chk("R5 one pulse", pulses, 1);

        // R6 R7: multiplexed group 0 on hold line 0, group 1 normal
        smp_in = '0; smp_en = 5'b00001; step(5);
        hold_en = 2'b01; hold_fall = 2'b00; grp_mux = 2'b01; grp_hsel = 2'b10;
        data_in = 8'h3A; hold_in[0] = 1'b1; step(5);
        hold_in[0] = 1'b0; data_in = 8'h65; smp_in[0] = 1'b1; step(5);
        chk("R7 word", last_word, 16'h06A5);
        chk("R10 no miss", hold_miss, 0);

        // R8 R10: latch kept, no new hold
        smp_in[0] = 1'b0; step(4); data_in = 8'h92; smp_in[0] = 1'b1; step(5);
        chk("R8 kept", last_word, 16'h09A2);
        chk("R10 miss set", hold_miss, 1);

        // R6: falling hold on line 1, disabled line 0 ignored
        grp_mux = 2'b11; hold_en = 2'b10; hold_fall = 2'b10;
        data_in = 8'hCB; hold_in = 2'b11; step(5);
        data_in = 8'hE1; hold_in = 2'b00; step(5);
        data_in = 8'h74; smp_in[0] = 1'b0; step(4); smp_in[0] = 1'b1; step(5);
        chk("R6 polarity and enable", last_word, 16'hE7A4);
        chk("R10 sticky", hold_miss, 1);

        // R11: stopped, no capture
        run_req = 1'b0; step(2);
        chk("R11 stopped level", runstop_out, 0);
        pulses = 0; smp_in[0] = 1'b0; step(4); smp_in[0] = 1'b1; step(5);
        chk("R11 no capture", pulses, 0);

        // R9: restart clears
        run_req = 1'b1; step(2);
        chk("R9 flag cleared", hold_miss, 0);
        chk("R11 running level", runstop_out, 1);
        smp_in[0] = 1'b0; step(4); smp_in[0] = 1'b1; step(5);
        chk("R9 latches cleared", last_word, 16'h0704);
        chk("R10 miss after start", hold_miss, 1);

        // R11: polarity
        runstop_inv = 1'b1; step(1);
        chk("R11 inverted running", runstop_out, 0);
        run_req = 1'b0; step(2);
        chk("R11 inverted stopped", runstop_out, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule